// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Lock-Aware Fill

This block keeps a small set of translation entries, 64 by default. Each entry pairs a tag word with a translation word. Software-style requests reach it over a single request channel and get answers on a response channel. There are three ways to place an entry. A staging register holds the tag that the next write will use. A fill operation picks its own slot. A slot write names the slot by address bits.

A fill walks the array one entry per cycle. It takes the lowest-numbered entry whose valid bit is clear. If every entry is valid, it takes the lowest-numbered entry whose lock bit is clear. If every entry is both valid and locked, the fill is dropped and a status pin is raised. A search walks the array in the same way. It returns the stored tag of the lowest-numbered valid entry whose tag equals the supplied key.

The request channel and the response channel both use valid/ready. Only one request is in flight at a time. `req_ready` is high only while the block is idle and has no response waiting. A response stays on `rsp_valid`/`rsp_rdata` without change until the cycle in which `rsp_ready` is high. The `fill_fail` status pin is a plain level.

Top module: `fa_tlb`

## Requirements
- R1: After reset, every entry reads as zero (invalid), the staging register reads zero, `fill_fail` is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is taken on a cycle with `req_valid` and `req_ready` both high. While `rsp_valid` is high, `req_ready` stays low. `rsp_valid` and `rsp_rdata` hold steady until they are taken with `rsp_ready`.
- R3: Opcode 0 loads the staging register from `req_wdata`. Opcode 1 returns the staging register.
- R4: Opcode 2 (fill) writes into the lowest-index entry whose translation word has bit 63 (valid) clear.
- R5: If all entries are valid, a fill writes into the lowest-index entry whose translation word has bit 6 (lock) clear.
- R6: If all entries are valid and locked, a fill changes no entry and sets `fill_fail`. The next fill that places an entry clears `fill_fail`.
- R7: Fill and slot writes store the staging register as the tag and `req_wdata` as the translation word.
- R8: Opcode 3 (slot write) picks the entry by `req_addr[8:3]` and ignores all other address bits.
- R9: Opcode 4 returns the translation word of entry `req_addr[8:3]`. Opcode 5 returns its tag.
- R10: Opcode 6 (search) returns the tag of the first valid entry whose tag equals `req_addr`. Invalid entries never match. With no match it returns zero.
- R11: For opcodes other than 2 and 6, `rsp_valid` is high in the cycle right after the accepting edge. For fill and search, it rises ENTRIES clock edges after that one. Every opcode returns a response, and writes return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 3 | Operation code |
| req_addr | input | DATA_W | Slot address or search key |
| req_wdata | input | DATA_W | Write data (staging value or translation word) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | DATA_W | Read result, zero for writes |
| fill_fail | output | 1 | Last completed fill found no usable slot |

## Verification
Register-style operations have their response due in the cycle right after the accepting edge. Fill and search responses are due exactly 64 edges later. The monitor timestamps each accepted handshake at the falling edge and checks the cycle in which `rsp_valid` first appears against the latency for that opcode. It compares data only on the cycle the response is taken. While back-pressure holds a response, the monitor checks at each falling edge that the response does not move. The bound checker counts the same windows with its own counter. `fill_fail` is read only once the response of the fill has been consumed, when its new value has already settled.

// File: rtl/fa_tlb_pkg.sv
`timescale 1ns/1ps
package fa_tlb_pkg;

  // Request operation codes
  typedef enum logic [2:0] {
    OP_STAGE_WR   = 3'd0,
    OP_STAGE_RD   = 3'd1,
    OP_FILL       = 3'd2,
    OP_SLOT_WR    = 3'd3,
    OP_SLOT_RDTTE = 3'd4,
    OP_SLOT_RDTAG = 3'd5,
    OP_SEARCH     = 3'd6,
    OP_NONE       = 3'd7
  } tlb_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_RESP = 2'd2
  } tlb_state_e;

endpackage

// File: rtl/fa_tlb_store.sv
`timescale 1ns/1ps
module fa_tlb_store #(
  parameter int ENTRIES = 64,
  parameter int DATA_W  = 64,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [DATA_W-1:0] wr_tag,
  input  logic [DATA_W-1:0] wr_tte,
  input  logic [IDXW-1:0]   rd_idx,
  output logic [DATA_W-1:0] rd_tag,
  output logic [DATA_W-1:0] rd_tte
);

  logic [DATA_W-1:0] tag_arr [ENTRIES];
  logic [DATA_W-1:0] tte_arr [ENTRIES];

  // One register pair per slot; each decodes its own write enable
  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic [DATA_W-1:0] tag_r;
    logic [DATA_W-1:0] tte_r;
    logic              hit_w;

    assign hit_w = wr_en && (wr_idx == IDXW'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_r <= '0;
        tte_r <= '0;
      end else if (hit_w) begin
        tag_r <= wr_tag;
        tte_r <= wr_tte;
      end
    end

    assign tag_arr[e] = tag_r;
    assign tte_arr[e] = tte_r;
  end

  assign rd_tag = tag_arr[rd_idx];
  assign rd_tte = tte_arr[rd_idx];

endmodule

// File: rtl/fa_tlb_scan.sv
`timescale 1ns/1ps
module fa_tlb_scan #(
  parameter int ENTRIES = 64,
  parameter int DATA_W  = 64,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] key,
  input  logic [DATA_W-1:0] cur_tag,
  input  logic              cur_valid,
  input  logic              cur_locked,
  output logic [IDXW-1:0]   idx,
  output logic              last,
  output logic              inv_found,
  output logic [IDXW-1:0]   inv_idx,
  output logic              unl_found,
  output logic [IDXW-1:0]   unl_idx,
  output logic              hit_found,
  output logic [DATA_W-1:0] hit_tag
);

  logic              active_q;
  logic [IDXW-1:0]   idx_q;
  logic [DATA_W-1:0] key_q;
  logic              inv_f_q, unl_f_q, hit_f_q;
  logic [IDXW-1:0]   inv_i_q, unl_i_q;
  logic [DATA_W-1:0] hit_t_q;

  // Running results merged with the entry under the cursor;
  // the earliest index found so far always wins.
  always_comb begin
    inv_found = inv_f_q || !cur_valid;
    inv_idx   = inv_f_q ? inv_i_q : idx_q;
    unl_found = unl_f_q || !cur_locked;
    unl_idx   = unl_f_q ? unl_i_q : idx_q;
    hit_found = hit_f_q || (cur_valid && (cur_tag == key_q));
    hit_tag   = hit_f_q ? hit_t_q : cur_tag;
  end

  assign idx  = idx_q;
  assign last = active_q && (idx_q == IDXW'(ENTRIES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      key_q    <= '0;
      inv_f_q  <= 1'b0;
      unl_f_q  <= 1'b0;
      hit_f_q  <= 1'b0;
      inv_i_q  <= '0;
      unl_i_q  <= '0;
      hit_t_q  <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      key_q    <= key;
      inv_f_q  <= 1'b0;
      unl_f_q  <= 1'b0;
      hit_f_q  <= 1'b0;
    end else if (active_q) begin
      inv_f_q <= inv_found;
      inv_i_q <= inv_idx;
      unl_f_q <= unl_found;
      unl_i_q <= unl_idx;
      hit_f_q <= hit_found;
      hit_t_q <= hit_tag;
      if (last) active_q <= 1'b0;
      else      idx_q    <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/fa_tlb_ctrl.sv
`timescale 1ns/1ps
module fa_tlb_ctrl
  import fa_tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int DATA_W  = 64,
  parameter int IDX_LSB = 3,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              fill_fail,
  output logic              wr_en,
  output logic [IDXW-1:0]   wr_idx,
  output logic [DATA_W-1:0] wr_tag,
  output logic [DATA_W-1:0] wr_tte,
  output logic [IDXW-1:0]   rd_idx,
  input  logic [DATA_W-1:0] rd_tag,
  input  logic [DATA_W-1:0] rd_tte,
  output logic              scan_start,
  output logic [DATA_W-1:0] scan_key,
  input  logic [IDXW-1:0]   scan_idx,
  input  logic              scan_last,
  input  logic              inv_found,
  input  logic [IDXW-1:0]   inv_idx,
  input  logic              unl_found,
  input  logic [IDXW-1:0]   unl_idx,
  input  logic              hit_found,
  input  logic [DATA_W-1:0] hit_tag
);

  tlb_state_e        st_q;
  tlb_op_e           op_q;
  tlb_op_e           op_in;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] stage_q;
  logic [DATA_W-1:0] rdata_q;
  logic              fail_q;
  logic              accept;
  logic [IDXW-1:0]   slot_idx;
  logic              fill_end;

  assign op_in     = tlb_op_e'(req_op);
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign slot_idx  = req_addr[IDX_LSB +: IDXW];
  assign rd_idx    = (st_q == ST_SCAN) ? scan_idx : slot_idx;

  assign scan_start = accept && ((op_in == OP_FILL) || (op_in == OP_SEARCH));
  assign scan_key   = req_addr;
  assign fill_end   = (st_q == ST_SCAN) && scan_last && (op_q == OP_FILL);

  // Write port: slot writes at acceptance, fills at the end of the walk
  always_comb begin
    wr_en  = 1'b0;
    wr_idx = slot_idx;
    wr_tag = stage_q;
    wr_tte = req_wdata;
    if (accept && (op_in == OP_SLOT_WR)) begin
      wr_en = 1'b1;
    end else if (fill_end) begin
      wr_tte = wdata_q;
      if (inv_found) begin
        wr_en  = 1'b1;
        wr_idx = inv_idx;
      end else if (unl_found) begin
        wr_en  = 1'b1;
        wr_idx = unl_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NONE;
      wdata_q <= '0;
      stage_q <= '0;
      rdata_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= op_in;
            wdata_q <= req_wdata;
            rdata_q <= '0;
            st_q    <= ST_RESP;
            case (op_in)
              OP_STAGE_WR:   stage_q <= req_wdata;
              OP_STAGE_RD:   rdata_q <= stage_q;
              OP_SLOT_RDTTE: rdata_q <= rd_tte;
              OP_SLOT_RDTAG: rdata_q <= rd_tag;
              OP_FILL,
              OP_SEARCH:     st_q    <= ST_SCAN;
              default:       ;
            endcase
          end
        end
        ST_SCAN: begin
          if (scan_last) begin
            st_q <= ST_RESP;
            if (op_q == OP_SEARCH) rdata_q <= hit_found ? hit_tag : '0;
            if (op_q == OP_FILL)   fail_q  <= !(inv_found || unl_found);
          end
        end
        ST_RESP: begin
          if (rsp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign fill_fail = fail_q;

endmodule

// File: rtl/fa_tlb.sv
`timescale 1ns/1ps
module fa_tlb #(
  parameter int ENTRIES   = 64,
  parameter int DATA_W    = 64,
  parameter int VALID_BIT = 63,
  parameter int LOCK_BIT  = 6,
  parameter int IDX_LSB   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              fill_fail
);

  localparam int IDXW = $clog2(ENTRIES);

  logic              wr_en;
  logic [IDXW-1:0]   wr_idx, rd_idx, scan_idx, inv_idx, unl_idx;
  logic [DATA_W-1:0] wr_tag, wr_tte, rd_tag, rd_tte, scan_key, hit_tag;
  logic              scan_start, scan_last, inv_found, unl_found, hit_found;

  fa_tlb_store #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_tag (wr_tag),
    .wr_tte (wr_tte),
    .rd_idx (rd_idx),
    .rd_tag (rd_tag),
    .rd_tte (rd_tte)
  );

  fa_tlb_scan #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (scan_start),
    .key        (scan_key),
    .cur_tag    (rd_tag),
    .cur_valid  (rd_tte[VALID_BIT]),
    .cur_locked (rd_tte[LOCK_BIT]),
    .idx        (scan_idx),
    .last       (scan_last),
    .inv_found  (inv_found),
    .inv_idx    (inv_idx),
    .unl_found  (unl_found),
    .unl_idx    (unl_idx),
    .hit_found  (hit_found),
    .hit_tag    (hit_tag)
  );

  fa_tlb_ctrl #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .IDX_LSB(IDX_LSB)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .fill_fail  (fill_fail),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_tag     (wr_tag),
    .wr_tte     (wr_tte),
    .rd_idx     (rd_idx),
    .rd_tag     (rd_tag),
    .rd_tte     (rd_tte),
    .scan_start (scan_start),
    .scan_key   (scan_key),
    .scan_idx   (scan_idx),
    .scan_last  (scan_last),
    .inv_found  (inv_found),
    .inv_idx    (inv_idx),
    .unl_found  (unl_found),
    .unl_idx    (unl_idx),
    .hit_found  (hit_found),
    .hit_tag    (hit_tag)
  );

endmodule

// File: rtl/fa_tlb_chk.sv
`timescale 1ns/1ps
module fa_tlb_chk #(
  parameter int ENTRIES = 64,
  parameter int DATA_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              fill_fail
);

  logic acc;
  logic scan_q;
  logic fill_q;
  int   cnt_q;

  assign acc = req_valid && req_ready;

  // Cycle counter from the accepting edge until the response shows up
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_q <= 1'b0;
      fill_q <= 1'b0;
      cnt_q  <= 0;
    end else if (acc) begin
      scan_q <= (req_op == 3'd2) || (req_op == 3'd6);
      fill_q <= (req_op == 3'd2);
      cnt_q  <= 0;
    end else if (!rsp_valid) begin
      cnt_q  <= cnt_q + 1;
    end
  end

  // R2: a held response does not change
  p_rsp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R2: no new request while a response waits
  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R11: walk operations answer after ENTRIES edges
  p_scan_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && scan_q |-> cnt_q == ENTRIES);

  // R11: register operations answer right away
  p_reg_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) && !scan_q |-> cnt_q == 0);

  // R6: the status pin only rises as a fill completes
  p_fail_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_fail) |-> fill_q && $rose(rsp_valid));

endmodule

bind fa_tlb fa_tlb_chk #(.ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/fa_tlb_test.sv
`timescale 1ns/1ps
module fa_tlb_test;

  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 64;
  localparam logic [63:0] VB = 64'h8000_0000_0000_0000;
  localparam logic [63:0] LB = 64'h0000_0000_0000_0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [63:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_rdata;
  logic        fill_fail;

  int  cyc = 0;
  int  n_chk = 0;
  int  n_bad = 0;
  bit  bp_on = 1'b0;
  bit  finished = 1'b0;

  typedef struct {
    logic [63:0] data;
    int          lat;
    string       req;
  } exp_t;
  exp_t sb[$];

  logic [63:0] m_tag [ENTRIES];
  logic [63:0] m_tte [ENTRIES];
  logic [63:0] m_stage = '0;

  fa_tlb uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .fill_fail(fill_fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) rsp_ready <= bp_on ? cyc[1] : 1'b1;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: latency, hold under back-pressure, data against the scoreboard
  initial begin
    bit          seen = 0;
    bit          hold = 0;
    logic [63:0] hold_d = '0;
    int          acc = 0;
    exp_t        e;
    forever begin
      @(negedge clk);
      if (hold) begin
        check("R2 hold valid", {63'b0, rsp_valid}, 64'd1);
        check("R2 hold data", rsp_rdata, hold_d);
      end
      hold   = rsp_valid && !rsp_ready;
      hold_d = rsp_rdata;
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          check("R2 unexpected response", 64'd1, 64'd0);
        end else begin
          if (!seen) begin
            seen = 1;
            check("R11 latency", 64'(cyc - acc), 64'(sb[0].lat));
            check("R2 ready low while busy", {63'b0, req_ready}, 64'd0);
          end
          if (rsp_ready) begin
            e = sb.pop_front();
            check(e.req, rsp_rdata, e.data);
            seen = 0;
          end
        end
      end
      if (req_valid && req_ready) acc = cyc + 1;
    end
  end

  task automatic issue(int op, logic [63:0] addr, logic [63:0] wdata,
                       logic [63:0] exp, int lat, string req);
    exp_t e;
    e.data = exp; e.lat = lat; e.req = req;
    sb.push_back(e);
    @(posedge clk); #1;
    req_op = 3'(op); req_addr = addr; req_wdata = wdata; req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int victim();
    for (int i = 0; i < ENTRIES; i++) if (!m_tte[i][63]) return i;
    for (int i = 0; i < ENTRIES; i++) if (!m_tte[i][6]) return i;
    return -1;
  endfunction

  function automatic logic [63:0] lookup(logic [63:0] key);
    for (int i = 0; i < ENTRIES; i++)
      if (m_tte[i][63] && m_tag[i] == key) return m_tag[i];
    return '0;
  endfunction

  task automatic stage_wr(logic [63:0] v);
    m_stage = v;
    issue(0, '0, v, '0, 0, "R3 stage write");
  endtask

  task automatic stage_rd(string req);
    issue(1, '0, '0, m_stage, 0, req);
  endtask

  task automatic slot_wr(int idx, logic [63:0] extra, logic [63:0] tte);
    m_tag[idx] = m_stage;
    m_tte[idx] = tte;
    issue(3, extra | (64'(idx) << 3), tte, '0, 0, "R8 slot write");
  endtask

  task automatic rd_tte(int idx, string req);
    issue(4, 64'(idx) << 3, '0, m_tte[idx], 0, req);
  endtask

  task automatic rd_tag(int idx, string req);
    issue(5, 64'(idx) << 3, '0, m_tag[idx], 0, req);
  endtask

  task automatic fill(logic [63:0] tte, string req);
    int v;
    v = victim();
    if (v >= 0) begin
      m_tag[v] = m_stage;
      m_tte[v] = tte;
    end
    issue(2, '0, tte, '0, ENTRIES, req);
  endtask

  task automatic search(logic [63:0] key, string req);
    issue(6, key, '0, lookup(key), ENTRIES, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin m_tag[i] = '0; m_tte[i] = '0; end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_ready", {63'b0, req_ready}, 64'd1);
    check("R1 rsp_valid", {63'b0, rsp_valid}, 64'd0);
    check("R1 fill_fail", {63'b0, fill_fail}, 64'd0);
    stage_rd("R1 stage zero");
    rd_tte(5, "R1 entry invalid");
    rd_tag(5, "R1 entry tag zero");
    search('0, "R1 R10 no valid entry");

    stage_wr(64'h1111_2222_3333_4440);
    stage_rd("R3 stage readback");
    fill(VB | 64'h100, "R4 fill into empty");
    rd_tag(0, "R7 fill tag from stage");
    rd_tte(0, "R4 fill word at slot 0");

    stage_wr(64'h2222_0000_0000_0002);
    slot_wr(2, '0, VB | 64'h200);
    rd_tag(2, "R7 slot tag from stage");
    rd_tte(2, "R9 slot word readback");
    stage_wr(64'h3333_0000_0000_0001);
    fill(VB | 64'h300, "R4 lowest invalid");
    rd_tag(1, "R4 fill landed at 1");
    stage_wr(64'h4444_0000_0000_0003);
    fill(VB | 64'h400, "R4 skip valid slot 2");
    rd_tag(3, "R4 fill landed at 3");
    rd_tte(3, "R4 word at 3");

    bp_on = 1'b1;
    search(64'h2222_0000_0000_0002, "R10 hit");
    search(64'h0000_0000_0000_DEAD, "R10 miss returns zero");
    stage_wr(64'h9999_0000_0000_0009);
    slot_wr(10, '0, 64'h0000_0000_0000_0123);
    search(64'h9999_0000_0000_0009, "R10 invalid entry no match");
    stage_wr(64'h8888_0000_0000_0008);
    slot_wr(9, 64'hFFF0_0000_0000_FE07, VB | 64'h900);
    rd_tag(9, "R8 extra address bits ignored");
    rd_tte(9, "R8 slot word at 9");
    rd_tte(10, "R9 invalid word readback");
    bp_on = 1'b0;

    for (int i = 0; i < ENTRIES; i++) begin
      stage_wr(64'hA5A5_0000_0000_0000 | 64'(i));
      slot_wr(i, '0, VB | ((i == 37 || i == 50) ? 64'h0 : LB) | (64'(i) << 13));
    end
    stage_wr(64'h5151_0000_0000_0001);
    fill(VB | LB | 64'h11, "R5 first unlocked");
    rd_tag(37, "R5 fill landed at 37");
    stage_wr(64'h5151_0000_0000_0002);
    fill(VB | LB | 64'h22, "R5 next unlocked");
    rd_tag(50, "R5 fill landed at 50");
    drain();
    check("R6 no fail yet", {63'b0, fill_fail}, 64'd0);

    bp_on = 1'b1;
    stage_wr(64'h5151_0000_0000_0003);
    fill(VB | LB | 64'h33, "R6 full and locked");
    drain();
    check("R6 fill_fail set", {63'b0, fill_fail}, 64'd1);
    search(64'h5151_0000_0000_0003, "R6 dropped fill not stored");
    rd_tag(0, "R6 slot 0 untouched");
    rd_tte(0, "R6 slot 0 word untouched");
    search(64'h5151_0000_0000_0002, "R10 hit at 50");
    bp_on = 1'b0;

    slot_wr(5, '0, 64'h0);
    stage_wr(64'h6161_0000_0000_0004);
    fill(VB | 64'h44, "R4 refill into freed slot");
    drain();
    check("R6 fill_fail cleared", {63'b0, fill_fail}, 64'd0);
    rd_tag(5, "R6 refill landed at 5");
    drain();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule